// File: doc/BRIEF.md
# Three-Wire Tuner Control Register Slave

This block receives configuration commands over a three-wire serial bus (a select line, a data line and a bit clock) and keeps the register file that steers a radio-tuner synthesizer: the reference and main divider ratios, the charge-pump current code, the crystal-buffer enable, a 3-bit DAC code, four switch drivers, the DAC mode bit, gain and offset codes for two alignment DACs, and a crystal load-tuning code. All three bus lines are sampled with the system clock through synchronisers. Each line therefore needs to stay at a level for at least three system clock periods.

A command is the set of bits clocked in while the select line is high. The bits arrive least significant first. The target register is chosen by two things: the number of rising bit-clock edges seen in that window (16 or 24) and address bits carried inside the word. The word is committed only after select falls, so the outputs change in one step and never show a half-shifted value. A command of any other length, or one that carries an unmapped address, is dropped and leaves every output unchanged.

Top module: `tw_tuner_regs`

## Requirements
- R1: After a synchronous active-low reset, every divider, code, gain, offset and mode output reads 0, `sw_drive` reads 0 (all switches off) and `osc_buf_en` reads 1.
- R2: A 24-bit command with word bits [23:22]=00 loads `ref_div` from bits [15:0], `dac3_code` from [18:16], the buffer-off flag from [19] (`osc_buf_en` is the inverse of that bit) and `pump_code` from [21:20].
- R3: A 24-bit command with bits [23:22]=01 loads `main_div` from [15:0], `am_mode` from [20] (1 = AM), and four switch bits from [19:16], with bit 16+k controlling switch k. A switch bit of 0 turns the switch on, so `sw_drive[k]` is the inverse of its bit.
- R4: A 16-bit command with bits [15:14]=00 loads `dac1_gain` from [7:0] and `dac1_offset` from [13:8]. With bits [15:14]=01, the same fields load `dac2_gain` and `dac2_offset`.
- R5: A 16-bit command with bit 15 = 1 loads `xtal_code` from bits [14:7]. Bits [6:0] are ignored.
- R6: Bit n of a command word is the data value sampled on the (n+1)-th rising bit-clock edge of the window. Sampling happens only while select is high.
- R7: A window holding a number of bit-clock edges other than 16 or 24 changes no output.
- R8: A 24-bit command with bits [23:22]=10 or 11 changes no output.
- R9: Outputs hold their values while a command is being shifted in. They take the new value within 8 system clock cycles after select falls.
- R10: Bit-clock edges while select is low are ignored. They neither change an output nor shift bits into the next command.
- R11: A command changes only the fields of the register it addresses. All other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Command window select, high during a command |
| bus_clk | input | 1 | Bit clock, data sampled on rising edge |
| bus_dat | input | 1 | Serial data, least significant bit first |
| ref_div | output | 16 | Reference divider ratio |
| pump_code | output | 2 | Charge-pump current code |
| osc_buf_en | output | 1 | Crystal buffer output enabled |
| dac3_code | output | 3 | Code of the 3-bit DAC |
| main_div | output | 16 | Main divider ratio |
| sw_drive | output | 4 | Switch k pulls low when bit k is 1 |
| am_mode | output | 1 | DAC mode, 1 = AM |
| dac1_gain | output | 8 | Gain code of alignment DAC 1 |
| dac1_offset | output | 6 | Offset code of alignment DAC 1 |
| dac2_gain | output | 8 | Gain code of alignment DAC 2 |
| dac2_offset | output | 6 | Offset code of alignment DAC 2 |
| xtal_code | output | 8 | Crystal load-tuning code |

## Verification
A wrong bit count or a stale shift position inside the receiver shows up at the very next command. Either a register that should have loaded keeps its old fields, or a dropped command writes into one. Both can be seen on the outputs within a few system cycles of select falling. A decode error moves the fields into the wrong output, or into the wrong bit positions within an output, and is caught by comparing every output against the expected state after each command. Stray bit-clock edges outside a window would shift the bits of the following word, so a known command is sent right after such edges.

// File: rtl/tw_pkg.sv
// Package: shared widths and field positions of the three-wire tuner register slave.
// Assumes: command words are at most LONG_BITS wide and bit 0 is received first.
package tw_pkg;
    localparam int LONG_BITS  = 24;
    localparam int SHORT_BITS = 16;
    localparam int DIV_W      = 16;
    localparam int GAIN_W     = 8;
    localparam int OFFS_W     = 6;
    localparam int XTAL_W     = 8;
    localparam int NUM_SW     = 4;
    localparam int DAC3_W     = 3;
    localparam int PUMP_W     = 2;
    localparam int NUM_ADAC   = 2;
    localparam int ADDR_W     = 2;
    // bit counter saturates one above the longest command
    localparam int LEN_W      = $clog2(LONG_BITS + 2);
    localparam int IDX_W      = $clog2(LONG_BITS);

    // long-word field positions
    localparam int L_ADDR_LO  = LONG_BITS - ADDR_W;
    localparam int L_DAC3_LO  = DIV_W;
    localparam int L_OSCOFF   = DIV_W + DAC3_W;
    localparam int L_PUMP_LO  = L_OSCOFF + 1;
    localparam int L_SW_LO    = DIV_W;
    localparam int L_AM       = DIV_W + NUM_SW;

    // short-word field positions
    localparam int S_ADDR_LO  = SHORT_BITS - ADDR_W;
    localparam int S_OFFS_LO  = GAIN_W;
    localparam int S_XSEL     = SHORT_BITS - 1;
    localparam int S_XTAL_LO  = S_XSEL - XTAL_W;

    localparam logic [ADDR_W-1:0] ADDR_REFDIV  = 2'b00;
    localparam logic [ADDR_W-1:0] ADDR_MAINDIV = 2'b01;
endpackage

// File: rtl/tw_sync.sv
// Module: multi-bit level synchroniser, one flop chain per bit.
// Assumes: each input bit is an independent slow level; no bus coherency is required.
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first stage: capture the asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_async;
                end
            end else begin : g_next
                // later stages: let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
// Module: command receiver. Counts bit-clock rising edges inside a select window,
// stores each sampled bit at its arrival index, and emits one strobe with the
// length and word after select falls.
// Assumes: inputs are already synchronised to clk; each level lasts several cycles.
module tw_shifter
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_s,
    input  logic                 bclk_s,
    input  logic                 dat_s,
    output logic                 cmd_stb,
    output logic [LEN_W-1:0]     cmd_len,
    output logic [LONG_BITS-1:0] cmd_word
);
    localparam logic [LEN_W-1:0] CNT_SAT = LEN_W'(LONG_BITS + 1);

    logic                 en_d, bclk_d;
    logic [LEN_W-1:0]     cnt;
    logic [LONG_BITS-1:0] shreg;
    logic                 en_fall, bclk_rise;

    assign en_fall   = en_d && !en_s;
    assign bclk_rise = bclk_s && !bclk_d;

    // delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d   <= 1'b0;
            bclk_d <= 1'b0;
        end else begin
            en_d   <= en_s;
            bclk_d <= bclk_s;
        end
    end

    // bit capture, edge counting and end-of-window hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            cmd_stb  <= 1'b0;
            cmd_len  <= '0;
            cmd_word <= '0;
        end else begin
            cmd_stb <= 1'b0;
            if (en_fall) begin
                cmd_stb  <= 1'b1;
                cmd_len  <= cnt;
                cmd_word <= shreg;
                cnt      <= '0;
                shreg    <= '0;
            end else if (en_s && bclk_rise) begin
                if (cnt < LEN_W'(LONG_BITS)) shreg[cnt[IDX_W-1:0]] <= dat_s;
                if (cnt != CNT_SAT)          cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: with select low the edge counter does not move
    a_r10_count_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !en_d) |=> $stable(cnt));
    // R7: the counter never runs past its saturation value
    a_r7_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_SAT);
    // R9: a strobe only follows the closing of a window
    a_r9_strobe_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (!en_d && $past(en_d)));
endmodule

// File: rtl/tw_regfile.sv
// Module: tuner register file. Decodes a finished command by length and address
// bits and loads the addressed register; anything unmapped is dropped.
// Assumes: cmd_stb is a single-cycle pulse with cmd_len and cmd_word valid.
module tw_regfile
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_stb,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic [LONG_BITS-1:0] cmd_word,
    output logic [DIV_W-1:0]     ref_div,
    output logic [PUMP_W-1:0]    pump_code,
    output logic                 osc_buf_en,
    output logic [DAC3_W-1:0]    dac3_code,
    output logic [DIV_W-1:0]     main_div,
    output logic [NUM_SW-1:0]    sw_drive,
    output logic                 am_mode,
    output logic [GAIN_W-1:0]    dac1_gain,
    output logic [OFFS_W-1:0]    dac1_offset,
    output logic [GAIN_W-1:0]    dac2_gain,
    output logic [OFFS_W-1:0]    dac2_offset,
    output logic [XTAL_W-1:0]    xtal_code
);
    logic                   is_long, is_short;
    logic [ADDR_W-1:0]      l_addr, s_addr;
    logic                   osc_off;
    logic [NUM_SW-1:0]      sw_off;
    logic [GAIN_W-1:0]      gain_q [NUM_ADAC];
    logic [OFFS_W-1:0]      offs_q [NUM_ADAC];

    assign is_long  = cmd_stb && (cmd_len == LEN_W'(LONG_BITS));
    assign is_short = cmd_stb && (cmd_len == LEN_W'(SHORT_BITS));
    assign l_addr   = cmd_word[L_ADDR_LO +: ADDR_W];
    assign s_addr   = cmd_word[S_ADDR_LO +: ADDR_W];

    // long register at address 00: reference divider and loop controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div   <= '0;
            dac3_code <= '0;
            osc_off   <= 1'b0;
            pump_code <= '0;
        end else if (is_long && l_addr == ADDR_REFDIV) begin
            ref_div   <= cmd_word[0 +: DIV_W];
            dac3_code <= cmd_word[L_DAC3_LO +: DAC3_W];
            osc_off   <= cmd_word[L_OSCOFF];
            pump_code <= cmd_word[L_PUMP_LO +: PUMP_W];
        end
    end

    // long register at address 01: main divider, switches and DAC mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_div <= '0;
            sw_off   <= '1;
            am_mode  <= 1'b0;
        end else if (is_long && l_addr == ADDR_MAINDIV) begin
            main_div <= cmd_word[0 +: DIV_W];
            sw_off   <= cmd_word[L_SW_LO +: NUM_SW];
            am_mode  <= cmd_word[L_AM];
        end
    end

    // short register with top bit set: crystal load tuning
    always_ff @(posedge clk) begin
        if (!rst_n)                          xtal_code <= '0;
        else if (is_short && cmd_word[S_XSEL]) xtal_code <= cmd_word[S_XTAL_LO +: XTAL_W];
    end

    generate
        for (genvar c = 0; c < NUM_ADAC; c++) begin : g_adac
            // short register at address c: gain and offset of alignment DAC c
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gain_q[c] <= '0;
                    offs_q[c] <= '0;
                end else if (is_short && s_addr == ADDR_W'(c)) begin
                    gain_q[c] <= cmd_word[0 +: GAIN_W];
                    offs_q[c] <= cmd_word[S_OFFS_LO +: OFFS_W];
                end
            end
        end
    endgenerate

    assign osc_buf_en  = !osc_off;
    assign sw_drive    = ~sw_off;
    assign dac1_gain   = gain_q[0];
    assign dac1_offset = offs_q[0];
    assign dac2_gain   = gain_q[1];
    assign dac2_offset = offs_q[1];

    // R9: no strobe, no change on any output
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> $stable({ref_div, pump_code, osc_buf_en, dac3_code, main_div, sw_drive,
                              am_mode, dac1_gain, dac1_offset, dac2_gain, dac2_offset, xtal_code}));
    // R7: a window of any other length is dropped
    a_r7_bad_length_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_len != LEN_W'(LONG_BITS) && cmd_len != LEN_W'(SHORT_BITS))
        |=> $stable({ref_div, pump_code, osc_buf_en, dac3_code, main_div, sw_drive,
                     am_mode, dac1_gain, dac1_offset, dac2_gain, dac2_offset, xtal_code}));
    // R8: long words with address 10 or 11 are dropped
    a_r8_unmapped_long_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_len == LEN_W'(LONG_BITS) && cmd_word[LONG_BITS-1])
        |=> $stable({ref_div, pump_code, osc_buf_en, dac3_code, main_div, sw_drive, am_mode}));
    // R11: a short command leaves the long registers alone
    a_r11_short_spares_long: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_len == LEN_W'(SHORT_BITS))
        |=> $stable({ref_div, pump_code, osc_buf_en, dac3_code, main_div, sw_drive, am_mode}));
endmodule

// File: rtl/tw_tuner_regs.sv
// Module: top of the three-wire tuner register slave. Synchronises the bus lines,
// receives a command per select window, and loads the decoded register file.
// Assumes: bus lines are asynchronous and each level lasts at least 3 clk periods.
module tw_tuner_regs
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_clk,
    input  logic                 bus_dat,
    output logic [DIV_W-1:0]     ref_div,
    output logic [PUMP_W-1:0]    pump_code,
    output logic                 osc_buf_en,
    output logic [DAC3_W-1:0]    dac3_code,
    output logic [DIV_W-1:0]     main_div,
    output logic [NUM_SW-1:0]    sw_drive,
    output logic                 am_mode,
    output logic [GAIN_W-1:0]    dac1_gain,
    output logic [OFFS_W-1:0]    dac1_offset,
    output logic [GAIN_W-1:0]    dac2_gain,
    output logic [OFFS_W-1:0]    dac2_offset,
    output logic [XTAL_W-1:0]    xtal_code
);
    logic [2:0]           bus_s;
    logic                 cmd_stb;
    logic [LEN_W-1:0]     cmd_len;
    logic [LONG_BITS-1:0] cmd_word;

    tw_sync #(.WIDTH(3), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_en, bus_clk, bus_dat}),
        .q_sync  (bus_s)
    );

    tw_shifter shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (bus_s[2]),
        .bclk_s   (bus_s[1]),
        .dat_s    (bus_s[0]),
        .cmd_stb  (cmd_stb),
        .cmd_len  (cmd_len),
        .cmd_word (cmd_word)
    );

    tw_regfile regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd_len     (cmd_len),
        .cmd_word    (cmd_word),
        .ref_div     (ref_div),
        .pump_code   (pump_code),
        .osc_buf_en  (osc_buf_en),
        .dac3_code   (dac3_code),
        .main_div    (main_div),
        .sw_drive    (sw_drive),
        .am_mode     (am_mode),
        .dac1_gain   (dac1_gain),
        .dac1_offset (dac1_offset),
        .dac2_gain   (dac2_gain),
        .dac2_offset (dac2_offset),
        .xtal_code   (xtal_code)
    );
endmodule

// File: tb/tw_tuner_regs_tb.sv
module tw_tuner_regs_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
    logic [15:0] ref_div, main_div;
    logic [1:0]  pump_code;
    logic        osc_buf_en, am_mode;
    logic [2:0]  dac3_code;
    logic [3:0]  sw_drive;
    logic [7:0]  dac1_gain, dac2_gain, xtal_code;
    logic [5:0]  dac1_offset, dac2_offset;

    // expected state, kept from the requirements
    logic [15:0] e_ref, e_main;
    logic [1:0]  e_pump;
    logic        e_osc, e_am;
    logic [2:0]  e_dac3;
    logic [3:0]  e_sw;
    logic [7:0]  e_g1, e_g2, e_x;
    logic [5:0]  e_o1, e_o2;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    tw_tuner_regs dut_i (.*);

    task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk(req, "ref_div", 32'(ref_div), 32'(e_ref));
        chk(req, "pump_code", 32'(pump_code), 32'(e_pump));
        chk(req, "osc_buf_en", 32'(osc_buf_en), 32'(e_osc));
        chk(req, "dac3_code", 32'(dac3_code), 32'(e_dac3));
        chk(req, "main_div", 32'(main_div), 32'(e_main));
        chk(req, "sw_drive", 32'(sw_drive), 32'(e_sw));
        chk(req, "am_mode", 32'(am_mode), 32'(e_am));
        chk(req, "dac1_gain", 32'(dac1_gain), 32'(e_g1));
        chk(req, "dac1_offset", 32'(dac1_offset), 32'(e_o1));
        chk(req, "dac2_gain", 32'(dac2_gain), 32'(e_g2));
        chk(req, "dac2_offset", 32'(dac2_offset), 32'(e_o2));
        chk(req, "xtal_code", 32'(xtal_code), 32'(e_x));
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [31:0] w, int n);
        for (int i = 0; i < n; i++) begin
            bus_dat = w[i];
            wait_clk(4);
            bus_clk = 1'b1;
            wait_clk(4);
            bus_clk = 1'b0;
        end
    endtask

    task automatic send(logic [31:0] w, int n);
        bus_en = 1'b1;
        wait_clk(4);
        send_bits(w, n);
        wait_clk(4);
        bus_en = 1'b0;
        wait_clk(8);   // R9: update window after select falls
    endtask

    task automatic t_reset();
        e_ref = '0; e_main = '0; e_pump = '0; e_osc = 1'b1; e_am = 1'b0; e_dac3 = '0;
        e_sw = '0; e_g1 = '0; e_g2 = '0; e_o1 = '0; e_o2 = '0; e_x = '0;
        chk_all("R1");
    endtask

    task automatic t_ref_reg();
        // R2 R6: addr 00, pump 10, buffer off, dac3 101, divider A53C
        send({8'h0, 2'b00, 2'b10, 1'b1, 3'b101, 16'hA53C}, 24);
        e_ref = 16'hA53C; e_pump = 2'b10; e_osc = 1'b0; e_dac3 = 3'b101;
        chk_all("R2");
        send({8'h0, 2'b00, 2'b11, 1'b0, 3'b010, 16'h0001}, 24);
        e_ref = 16'h0001; e_pump = 2'b11; e_osc = 1'b1; e_dac3 = 3'b010;
        chk_all("R2");
    endtask

    task automatic t_main_reg();
        // R3: switch bits 1010 -> drive 0101, AM mode
        send({8'h0, 2'b01, 1'b0, 1'b1, 4'b1010, 16'h1234}, 24);
        e_main = 16'h1234; e_sw = 4'b0101; e_am = 1'b1;
        chk_all("R3");
        send({8'h0, 2'b01, 1'b0, 1'b0, 4'b0111, 16'h8000}, 24);
        e_main = 16'h8000; e_sw = 4'b1000; e_am = 1'b0;
        chk_all("R3");
    endtask

    task automatic t_adac();
        // R4 R11: DAC1 then DAC2, each leaving the other intact
        send({16'h0, 2'b00, 6'h2A, 8'hC3}, 16);
        e_g1 = 8'hC3; e_o1 = 6'h2A;
        chk_all("R4");
        send({16'h0, 2'b01, 6'h15, 8'h5E}, 16);
        e_g2 = 8'h5E; e_o2 = 6'h15;
        chk_all("R11");
    endtask

    task automatic t_xtal();
        // R5: top bit 1, code B7, low bits ignored
        send({16'h0, 1'b1, 8'hB7, 7'h55}, 16);
        e_x = 8'hB7;
        chk_all("R5");
    endtask

    task automatic t_bad_len();
        // R7: 15, 17, 23 and 25 edges are dropped
        send({16'h0, 2'b00, 6'h01, 8'h01}, 15);
        chk_all("R7");
        send({15'h0, 1'b0, 2'b00, 6'h02, 8'h02}, 17);
        chk_all("R7");
        send({8'h0, 2'b01, 6'h0, 16'hFFFF}, 23);
        chk_all("R7");
        send({7'h0, 1'b0, 2'b00, 6'h0, 16'hFFFF}, 25);
        chk_all("R7");
    endtask

    task automatic t_bad_addr();
        // R8: long addresses 10 and 11
        send({8'h0, 2'b10, 6'h3F, 16'hFFFF}, 24);
        chk_all("R8");
        send({8'h0, 2'b11, 6'h3F, 16'hFFFF}, 24);
        chk_all("R8");
    endtask

    task automatic t_midway();
        // R9: outputs hold mid-command, then update after select falls
        logic [31:0] w = {16'h0, 2'b00, 6'h0B, 8'h77};
        bus_en = 1'b1;
        wait_clk(4);
        send_bits(w, 16);
        wait_clk(10);
        chk_all("R9");
        bus_en = 1'b0;
        wait_clk(8);
        e_g1 = 8'h77; e_o1 = 6'h0B;
        chk_all("R9");
    endtask

    task automatic t_idle_clk();
        // R10: edges with select low, then a clean DAC2 write
        bus_en = 1'b0;
        send_bits(32'hFFFF_FFFF, 5);
        wait_clk(8);
        chk_all("R10");
        send({16'h0, 2'b01, 6'h33, 8'hA1}, 16);
        e_g2 = 8'hA1; e_o2 = 6'h33;
        chk_all("R10");
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_ref_reg();
        t_main_reg();
        t_adac();
        t_xtal();
        t_bad_len();
        t_bad_addr();
        t_midway();
        t_idle_clk();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule